// File: doc/BRIEF.md
# Multi-tap divider and time base

This block holds one binary divider chain that advances on a tick from one of three sources. Its low stages form an eight-stage divider and its high stages a seven-stage prescaler, so the chain is fifteen bits wide. Three consumers take their own tap from the chain, each through its own option select:

- a display-drive clock;
- a sounder clock;
- a periodic time-base event.

The time-base event leaves the block as a one-cycle tick that an external event counter can use as its clock. The same event also raises an interrupt request flag.

Once the flag is set, the block issues a one-cycle call request with the fixed vector address 14h. It does so only when the interrupt is enabled and the return stack has a free entry. Issuing the call consumes the flag. If the call is blocked, the flag waits until it can be serviced or until software clears it. All ticks are single-cycle enables in the `clk` domain. Reset is synchronous and active-high.

Top module: `mtap_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the chain and every output go to zero at that edge.
- R2: `src_sel` picks the tick that advances the chain: 0 selects `wdt_tick`, 1 selects `rtc_tick`, 2 selects `ins_tick`. The chain advances by one at each edge where the selected tick is high. Ticks that are not selected have no effect on any output.
- R3: With `src_sel` = 3 the chain holds its value whatever the ticks do, so `lcd_clk` and `buz_clk` stay constant as long as their selects stay constant.
- R4: `lcd_clk` is a square wave at source/2^(2+s), where s = `lcd_sel`, clamped to 6 (source/2^8). It equals chain bit 1+s after each edge.
- R5: `buz_clk` is a square wave at source/2^(2+`buz_sel`), covering source/4 to source/512. It equals chain bit 1+`buz_sel` after each edge.
- R6: `tb_tick` is high for exactly one cycle after the edge at which chain bit 11+`tb_sel` rises. This gives one pulse every 2^(12+`tb_sel`) source ticks, from 2^12 to 2^15.
- R7: The edge after a `tb_tick` pulse sets `irq_flag`. A set takes priority over a take or a software clear at the same edge.
- R8: At an edge where `irq_flag`, `irq_en` are high and `stack_full` is low, `call_req` is driven high for one cycle. The same edge clears `irq_flag`.
- R9: While `irq_en` is low or `stack_full` is high, a set `irq_flag` stays set and no call is requested. The call follows once the block is unblocked.
- R10: `flag_clr` high at an edge clears `irq_flag`, unless a `tb_tick` pulse sets it at the same edge.
- R11: `call_vec` carries 14h (12 bits) in the cycle `call_req` is high and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Chain source select: 0 watchdog osc, 1 RTC osc, 2 instruction clock, 3 off |
| wdt_tick | input | 1 | Watchdog-oscillator tick |
| rtc_tick | input | 1 | Real-time-clock oscillator tick |
| ins_tick | input | 1 | Instruction-clock tick |
| lcd_sel | input | 3 | Display clock tap option |
| buz_sel | input | 3 | Sounder clock tap option |
| tb_sel | input | 2 | Time-base period option |
| irq_en | input | 1 | Time-base interrupt enable |
| stack_full | input | 1 | Return stack has no free entry |
| flag_clr | input | 1 | Software clear of the request flag |
| lcd_clk | output | 1 | Display-drive clock |
| buz_clk | output | 1 | Sounder clock |
| tb_tick | output | 1 | One-cycle time-base pulse, also for an external counter |
| irq_flag | output | 1 | Time-base interrupt request flag |
| call_req | output | 1 | One-cycle request for a call to the vector |
| call_vec | output | 12 | Call target address, valid with `call_req` |

## Verification
The hardest case to reach is a request flag that is raised while the dispatch is blocked, so that it must survive many cycles before a call is taken or a software clear arrives. Reaching it takes thousands of source ticks to get through a time-base period. The bench therefore runs the instruction tick every cycle on the shortest period while holding the stack full or the enable low. It waits until its own model has raised the flag, then releases the block or pulses the clear. It also holds the clear high across a whole period, so that the time-base set and the clear meet at one edge.

// File: rtl/mtap_pkg.sv
package mtap_pkg;
  typedef enum logic [1:0] {
    SRC_WDT   = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_INSTR = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;
endpackage

// File: rtl/mtap_src_sel.sv
module mtap_src_sel
  import mtap_pkg::*;
(
  input  src_e sel,
  input  logic wdt_tick,
  input  logic rtc_tick,
  input  logic ins_tick,
  output logic tick
);
  always_comb begin
    unique case (sel)
      SRC_WDT:   tick = wdt_tick;
      SRC_RTC:   tick = rtc_tick;
      SRC_INSTR: tick = ins_tick;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/mtap_chain.sv
module mtap_chain #(
  parameter int DIV_STAGES = 8,
  parameter int PRE_BITS   = 7,
  localparam int W = DIV_STAGES + PRE_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  logic [DIV_STAGES-1:0] div_q, div_d;
  logic                  div_wrap;

  // low stages: plain divider
  always_comb begin
    div_d    = tick ? div_q + 1'b1 : div_q;
    div_wrap = tick && (&div_q);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_d;
  end

  // high stages: prescaler advanced by divider wrap
  generate
    if (PRE_BITS > 0) begin : g_pre
      logic [PRE_BITS-1:0] pre_q, pre_d;
      always_comb pre_d = div_wrap ? pre_q + 1'b1 : pre_q;
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
      end
      assign cnt_q = {pre_q, div_q};
      assign cnt_d = {pre_d, div_d};
    end else begin : g_nopre
      assign cnt_q = div_q;
      assign cnt_d = div_d;
    end
  endgenerate
endmodule

// File: rtl/mtap_tap.sv
module mtap_tap #(
  parameter int W       = 15,
  parameter int SEL_W   = 3,
  parameter int MIN_EXP = 2,
  parameter int MAX_EXP = 8,
  parameter bit PULSE   = 1'b0,
  localparam int SPAN   = MAX_EXP - MIN_EXP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     cnt_q,
  input  logic [W-1:0]     cnt_d,
  input  logic [SEL_W-1:0] sel,
  output logic             out
);
  logic [SEL_W-1:0] sel_c;
  int               idx;
  logic             bit_d, bit_q;

  always_comb begin
    sel_c = (sel > SEL_W'(SPAN)) ? SEL_W'(SPAN) : sel;
    idx   = MIN_EXP - 1 + int'(sel_c);
    bit_d = 1'b0;
    bit_q = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k == idx) begin
        bit_d = cnt_d[k];
        bit_q = cnt_q[k];
      end
    end
  end

  generate
    if (PULSE) begin : g_edge
      always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= bit_d & ~bit_q;
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= bit_d;
      end
    end
  endgenerate
endmodule

// File: rtl/mtap_irq.sv
module mtap_irq #(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CALL_VEC = 12'h014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_pulse,
  input  logic              irq_en,
  input  logic              stack_full,
  input  logic              sw_clr,
  output logic              flag_q,
  output logic              call_q,
  output logic [ADDR_W-1:0] vec_q
);
  logic take;

  always_comb take = flag_q && irq_en && !stack_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (tb_pulse)             flag_q <= 1'b1;
      else if (take || sw_clr)  flag_q <= 1'b0;
      call_q <= take;
      vec_q  <= take ? CALL_VEC : '0;
    end
  end
endmodule

// File: rtl/mtap_timebase.sv
module mtap_timebase #(
  parameter int DIV_STAGES = 8,
  parameter int PRE_BITS   = 7,
  parameter int LCD_SEL_W  = 3,
  parameter int LCD_MIN    = 2,
  parameter int LCD_MAX    = 8,
  parameter int BUZ_SEL_W  = 3,
  parameter int BUZ_MIN    = 2,
  parameter int BUZ_MAX    = 9,
  parameter int TB_SEL_W   = 2,
  parameter int TB_MIN     = 12,
  parameter int TB_MAX     = 15,
  parameter int ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CALL_VEC = 12'h014,
  localparam int W = DIV_STAGES + PRE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           src_sel,
  input  logic                 wdt_tick,
  input  logic                 rtc_tick,
  input  logic                 ins_tick,
  input  logic [LCD_SEL_W-1:0] lcd_sel,
  input  logic [BUZ_SEL_W-1:0] buz_sel,
  input  logic [TB_SEL_W-1:0]  tb_sel,
  input  logic                 irq_en,
  input  logic                 stack_full,
  input  logic                 flag_clr,
  output logic                 lcd_clk,
  output logic                 buz_clk,
  output logic                 tb_tick,
  output logic                 irq_flag,
  output logic                 call_req,
  output logic [ADDR_W-1:0]    call_vec
);
  logic         src_tick;
  logic [W-1:0] cnt_q, cnt_d;

  mtap_src_sel u_src (
    .sel      (mtap_pkg::src_e'(src_sel)),
    .wdt_tick (wdt_tick),
    .rtc_tick (rtc_tick),
    .ins_tick (ins_tick),
    .tick     (src_tick)
  );

  mtap_chain #(.DIV_STAGES(DIV_STAGES), .PRE_BITS(PRE_BITS)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .tick  (src_tick),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  mtap_tap #(.W(W), .SEL_W(LCD_SEL_W), .MIN_EXP(LCD_MIN), .MAX_EXP(LCD_MAX),
             .PULSE(1'b0)) u_lcd (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_d(cnt_d), .sel(lcd_sel), .out(lcd_clk)
  );

  mtap_tap #(.W(W), .SEL_W(BUZ_SEL_W), .MIN_EXP(BUZ_MIN), .MAX_EXP(BUZ_MAX),
             .PULSE(1'b0)) u_buz (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_d(cnt_d), .sel(buz_sel), .out(buz_clk)
  );

  mtap_tap #(.W(W), .SEL_W(TB_SEL_W), .MIN_EXP(TB_MIN), .MAX_EXP(TB_MAX),
             .PULSE(1'b1)) u_tb (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_d(cnt_d), .sel(tb_sel), .out(tb_tick)
  );

  mtap_irq #(.ADDR_W(ADDR_W), .CALL_VEC(CALL_VEC)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .tb_pulse   (tb_tick),
    .irq_en     (irq_en),
    .stack_full (stack_full),
    .sw_clr     (flag_clr),
    .flag_q     (irq_flag),
    .call_q     (call_req),
    .vec_q      (call_vec)
  );
endmodule

// File: rtl/mtap_timebase_chk.sv
module mtap_timebase_chk #(
  parameter int LCD_SEL_W = 3,
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CALL_VEC = 12'h014
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           src_sel,
  input logic [LCD_SEL_W-1:0] lcd_sel,
  input logic                 irq_en,
  input logic                 stack_full,
  input logic                 flag_clr,
  input logic                 lcd_clk,
  input logic                 buz_clk,
  input logic                 tb_tick,
  input logic                 irq_flag,
  input logic                 call_req,
  input logic [ADDR_W-1:0]    call_vec
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!lcd_clk && !buz_clk && !tb_tick && !irq_flag && !call_req));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd3 && lcd_sel == $past(lcd_sel)) |=> $stable(lcd_clk));

  p_tick_single_r6: assert property (@(posedge clk) disable iff (rst)
    tb_tick |=> !tb_tick);

  p_tick_sets_r7: assert property (@(posedge clk) disable iff (rst)
    tb_tick |=> irq_flag);

  p_call_cause_r8: assert property (@(posedge clk) disable iff (rst)
    call_req |-> $past(irq_flag && irq_en && !stack_full));

  p_call_consumes_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && irq_en && !stack_full && !tb_tick) |=> !irq_flag);

  p_blocked_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && (!irq_en || stack_full) && !flag_clr) |=> (irq_flag && !call_req));

  p_sw_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !tb_tick) |=> !irq_flag);

  p_vec_valid_r11: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec == CALL_VEC));

  p_vec_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !call_req |-> (call_vec == '0));
endmodule

bind mtap_timebase mtap_timebase_chk #(
  .LCD_SEL_W (LCD_SEL_W),
  .ADDR_W    (ADDR_W),
  .CALL_VEC  (CALL_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_sel    (src_sel),
  .lcd_sel    (lcd_sel),
  .irq_en     (irq_en),
  .stack_full (stack_full),
  .flag_clr   (flag_clr),
  .lcd_clk    (lcd_clk),
  .buz_clk    (buz_clk),
  .tb_tick    (tb_tick),
  .irq_flag   (irq_flag),
  .call_req   (call_req),
  .call_vec   (call_vec)
);

// File: tb/mtap_timebase_test.sv
`timescale 1ns/1ps
module mtap_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd2;
  logic        wdt_tick = 1'b0, rtc_tick = 1'b0, ins_tick = 1'b0;
  logic [2:0]  lcd_sel = '0, buz_sel = '0;
  logic [1:0]  tb_sel = '0;
  logic        irq_en = 1'b0, stack_full = 1'b0, flag_clr = 1'b0;
  logic        lcd_clk, buz_clk, tb_tick, irq_flag, call_req;
  logic [11:0] call_vec;

  int nvec = 0;
  int nbad = 0;
  int ncyc = 0;

  // bench model state
  logic [14:0] m_cnt = '0;
  logic        e_lcd = 0, e_buz = 0, e_tbt = 0, e_flag = 0, e_call = 0;
  logic [11:0] e_vec = '0;

  always #2.5 clk = ~clk;

  mtap_timebase uut (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .wdt_tick(wdt_tick), .rtc_tick(rtc_tick), .ins_tick(ins_tick),
    .lcd_sel(lcd_sel), .buz_sel(buz_sel), .tb_sel(tb_sel),
    .irq_en(irq_en), .stack_full(stack_full), .flag_clr(flag_clr),
    .lcd_clk(lcd_clk), .buz_clk(buz_clk), .tb_tick(tb_tick),
    .irq_flag(irq_flag), .call_req(call_req), .call_vec(call_vec)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 180000) begin
      nbad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 180000", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, ncyc);
    end
  endtask

  // one clock: model advances at the edge, outputs compared at the falling edge
  task automatic step(input string tag);
    logic        tk;
    logic [14:0] nxt;
    int          li, ti;
    logic        take, nflag;
    @(posedge clk);
    if (rst) begin
      m_cnt = '0; e_lcd = 0; e_buz = 0; e_tbt = 0; e_flag = 0; e_call = 0; e_vec = '0;
    end else begin
      case (src_sel)
        2'd0: tk = wdt_tick;
        2'd1: tk = rtc_tick;
        2'd2: tk = ins_tick;
        default: tk = 1'b0;
      endcase
      nxt   = m_cnt + {14'd0, tk};
      li    = (lcd_sel > 3'd6) ? 6 : int'(lcd_sel);
      ti    = 11 + int'(tb_sel);
      take  = e_flag && irq_en && !stack_full;
      nflag = e_tbt ? 1'b1 : ((take || flag_clr) ? 1'b0 : e_flag);
      e_lcd = nxt[1 + li];
      e_buz = nxt[1 + int'(buz_sel)];
      e_tbt = nxt[ti] && !m_cnt[ti];
      e_flag = nflag;
      e_call = take;
      e_vec  = take ? 12'h014 : 12'h000;
      m_cnt  = nxt;
    end
    @(negedge clk);
    chk({tag, " R4"},  "lcd_clk",  int'(lcd_clk),  int'(e_lcd));
    chk({tag, " R5"},  "buz_clk",  int'(buz_clk),  int'(e_buz));
    chk({tag, " R6"},  "tb_tick",  int'(tb_tick),  int'(e_tbt));
    chk({tag, " R7"},  "irq_flag", int'(irq_flag), int'(e_flag));
    chk({tag, " R8"},  "call_req", int'(call_req), int'(e_call));
    chk({tag, " R11"}, "call_vec", int'(call_vec), int'(e_vec));
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1; ins_tick = 1'b1;
    for (int i = 0; i < 3; i++) step("R1");
    chk("R1", "lcd_clk after reset", int'(lcd_clk), 0);
    chk("R1", "irq_flag after reset", int'(irq_flag), 0);
    rst = 1'b0;

    // R4/R5: sweep tap options with the instruction tick every cycle
    src_sel = 2'd2;
    for (int i = 0; i < 2048; i++) begin
      lcd_sel = 3'((i / 32) % 8);
      buz_sel = 3'((i / 256) % 8);
      ins_tick = 1'b1;
      step("R4R5 sweep");
    end

    // R2: each source advances only on its own tick
    lcd_sel = 3'd0; buz_sel = 3'd1;
    for (int s = 0; s < 3; s++) begin
      src_sel = 2'(s);
      for (int i = 0; i < 300; i++) begin
        wdt_tick = (s == 0) ? (i % 3 == 0) : 1'b1;
        rtc_tick = (s == 1) ? (i % 2 == 0) : 1'b1;
        ins_tick = (s == 2) ? (i % 5 != 0) : 1'b1;
        step("R2 source select");
      end
    end

    // R3: source off, every tick active, chain must hold
    src_sel = 2'd3; wdt_tick = 1; rtc_tick = 1; ins_tick = 1;
    for (int i = 0; i < 200; i++) step("R3 source off");
    chk("R3", "lcd_clk held", int'(lcd_clk), int'(e_lcd));

    // R6/R7/R8: every time-base period with dispatch enabled
    src_sel = 2'd2; ins_tick = 1'b1; irq_en = 1'b1; stack_full = 1'b0;
    for (int t = 0; t < 4; t++) begin
      tb_sel = 2'(t);
      for (int i = 0; i < (1 << (12 + t)) + 40; i++) step("R6 period");
    end

    // R9: stack full blocks the call, flag waits
    tb_sel = 2'd0; stack_full = 1'b1;
    while (!e_flag) step("R9 stack full");
    for (int i = 0; i < 50; i++) step("R9 stack full hold");
    chk("R9", "flag held while stack full", int'(irq_flag), 1);
    stack_full = 1'b0;
    for (int i = 0; i < 3; i++) step("R9 release");

    // R9: enable low blocks the call
    irq_en = 1'b0;
    while (!e_flag) step("R9 disabled");
    for (int i = 0; i < 50; i++) step("R9 disabled hold");
    chk("R9", "flag held while disabled", int'(irq_flag), 1);

    // R10: software clear of a pending flag
    flag_clr = 1'b1;
    step("R10 clear");
    flag_clr = 1'b0;
    for (int i = 0; i < 5; i++) step("R10 after clear");
    chk("R10", "flag after clear", int'(irq_flag), 0);

    // R10/R7: clear held through a period, set wins at the pulse edge
    flag_clr = 1'b1;
    for (int i = 0; i < 4200; i++) step("R10 clear vs set");
    flag_clr = 1'b0;
    irq_en = 1'b1;
    for (int i = 0; i < 20; i++) step("R8 tail");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule